// File: doc/BRIEF.md
# Analog Display Output Power and Sync Gate

This block is the last stage in front of the pins of an analog display port. It takes raw, active-high horizontal and vertical sync from several display pipes and chooses one pipe. It applies the programmed polarity to each sync line and decides whether the DAC is powered. It also decides whether each sync line toggles or is parked at its idle level. A monitor reads these combinations as power-saving requests. The DAC core, timing generation and mode checks are outside this block.

Software loads a new setting through a one-cycle write strobe. The setting holds a power state, two polarity flags and a pipe number. It is held as pending and only replaces the applied setting at the next frame start. A frame start is a rising edge of the raw vertical sync from the pipe selected by the applied setting. Changes therefore never cut a sync pulse short. The applied setting is decoded from a cleared state every time, so no suppression or enable bit carries over from an earlier state. All three outputs are registered, and they follow the raw sync inputs one clock later.

Top module: `analog_out_stage`

## Requirements
- R1: Power state 0 (full on): `dac_en` is 1 and both sync outputs follow their raw inputs with the programmed polarity.
- R2: Power state 1 (standby): `dac_en` is 1, `hsync_out` is held at its idle level, and `vsync_out` keeps following its raw input.
- R3: Power state 2 (suspend): `dac_en` is 1, `vsync_out` is held at its idle level, and `hsync_out` keeps following its raw input.
- R4: Power state 3 (off): `dac_en` is 0 and both sync outputs are held at their idle levels.
- R5: A polarity flag of 1 makes that output equal to the raw sync. A flag of 0 makes it the inverted raw sync. A held output sits at the inverse of its flag, which is the idle level for that polarity.
- R6: `cfg_pipe` selects which pipe drives both outputs: value 0 picks bit 0 of `pipe_hsync`/`pipe_vsync`, and value 1 picks bit 1.
- R7: A write with `cfg_wr`=1 changes no output directly. The written setting becomes the applied one at the first clock edge where the raw vsync of the currently applied pipe is 1 and was 0 at the previous edge. Each output at an edge is computed from that edge's raw inputs and applied setting, so it appears one clock later.
- R8: When moving from one power state to another, no enable or suppression from the earlier state remains. For example, going from standby to suspend makes hsync toggle again.
- R9: Reset applies and pends power state 3 with both polarity flags 0 and pipe 0: `dac_en`=0, `hsync_out`=1, `vsync_out`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | One-cycle strobe that loads the pending setting |
| cfg_pwr | input | 2 | Power state: 0 on, 1 standby, 2 suspend, 3 off |
| cfg_hpos | input | 1 | 1 = hsync active high, 0 = active low |
| cfg_vpos | input | 1 | 1 = vsync active high, 0 = active low |
| cfg_pipe | input | SEL_W | Source pipe number |
| pipe_hsync | input | NUM_PIPES | Raw active-high hsync, one bit per pipe |
| pipe_vsync | input | NUM_PIPES | Raw active-high vsync, one bit per pipe |
| dac_en | output | 1 | DAC power enable |
| hsync_out | output | 1 | Horizontal sync to the pin |
| vsync_out | output | 1 | Vertical sync to the pin |

## Verification
On every cycle, the assertions check the per-state rules against the applied setting: the DAC is dark only when off, and a suppressed line sits at the inverse of its polarity flag. They also check that the applied setting changes only in the cycle after a frame start. Some behaviours only the bench can show, because it compares all three outputs on every cycle against its own model with its own frame-edge tracking. These are that an enabled line follows the correct pipe with the correct polarity, that a write stays pending until the right vsync edge, and that a state change leaves nothing behind.

// File: rtl/aos_pkg.sv
package aos_pkg;

  typedef enum logic [1:0] {
    PWR_ON      = 2'd0,
    PWR_STANDBY = 2'd1,
    PWR_SUSPEND = 2'd2,
    PWR_OFF     = 2'd3
  } pwr_e;

  typedef struct packed {
    pwr_e pwr;
    logic h_pos;
    logic v_pos;
  } mode_t;

  typedef struct packed {
    logic dac_on;
    logic h_kill;
    logic v_kill;
  } gate_t;

  localparam mode_t MODE_RESET = '{pwr: PWR_OFF, h_pos: 1'b0, v_pos: 1'b0};

  // Every call starts from an all-clear gate, so nothing survives a state change.
  function automatic gate_t decode_gate(pwr_e p);
    gate_t g;
    g = '0;
    case (p)
      PWR_ON:      g.dac_on = 1'b1;
      PWR_STANDBY: begin g.dac_on = 1'b1; g.h_kill = 1'b1; end
      PWR_SUSPEND: begin g.dac_on = 1'b1; g.v_kill = 1'b1; end
      default:     begin g.h_kill = 1'b1; g.v_kill = 1'b1; end
    endcase
    return g;
  endfunction

  // Pin level for one sync line: parked at the idle level or polarity-adjusted.
  function automatic logic pin_level(logic raw, logic pos, logic kill);
    if (kill) return !pos;
    return pos ? raw : !raw;
  endfunction

endpackage

// File: rtl/aos_pipe_mux.sv
module aos_pipe_mux #(
  parameter int NUM_PIPES = 2,
  parameter int SEL_W     = 1
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic [NUM_PIPES-1:0] hs_in,
  input  logic [NUM_PIPES-1:0] vs_in,
  output logic                 hs_out,
  output logic                 vs_out
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_PIPES - 1);

  logic in_range;
  assign in_range = (sel <= LAST);

  always_comb begin
    hs_out = hs_in[0];
    vs_out = vs_in[0];
    for (int i = 0; i < NUM_PIPES; i++) begin
      if (in_range && sel == SEL_W'(i)) begin
        hs_out = hs_in[i];
        vs_out = vs_in[i];
      end
    end
  end
endmodule

// File: rtl/aos_frame_edge.sv
module aos_frame_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic vs,
  output logic frame_start
);
  logic vs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_prev <= 1'b0;
    else        vs_prev <= vs;
  end

  assign frame_start = vs & ~vs_prev;
endmodule

// File: rtl/aos_cfg_regs.sv
module aos_cfg_regs
  import aos_pkg::*;
#(
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  mode_t            wr_mode,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             frame_start,
  output mode_t            act_mode,
  output logic [SEL_W-1:0] act_sel,
  output mode_t            nxt_mode,
  output logic [SEL_W-1:0] nxt_sel
);
  mode_t            pend_mode;
  logic [SEL_W-1:0] pend_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_mode <= MODE_RESET;
      pend_sel  <= '0;
    end else if (wr_en) begin
      pend_mode <= wr_mode;
      pend_sel  <= wr_sel;
    end
  end

  assign nxt_mode = frame_start ? pend_mode : act_mode;
  assign nxt_sel  = frame_start ? pend_sel  : act_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode <= MODE_RESET;
      act_sel  <= '0;
    end else begin
      act_mode <= nxt_mode;
      act_sel  <= nxt_sel;
    end
  end
endmodule

// File: rtl/aos_sync_lane.sv
module aos_sync_lane
  import aos_pkg::*;
#(
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic pos,
  input  logic kill,
  output logic pin
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= RST_LEVEL;
    else        pin <= pin_level(raw, pos, kill);
  end
endmodule

// File: rtl/analog_out_stage.sv
module analog_out_stage
  import aos_pkg::*;
#(
  parameter  int NUM_PIPES = 2,
  localparam int SEL_W     = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_pwr,
  input  logic                 cfg_hpos,
  input  logic                 cfg_vpos,
  input  logic [SEL_W-1:0]     cfg_pipe,
  input  logic [NUM_PIPES-1:0] pipe_hsync,
  input  logic [NUM_PIPES-1:0] pipe_vsync,
  output logic                 dac_en,
  output logic                 hsync_out,
  output logic                 vsync_out
);
  localparam int  LANES    = 2;
  localparam logic IDLE_RST = !MODE_RESET.h_pos;

  mode_t            wr_mode, act_mode, nxt_mode;
  logic [SEL_W-1:0] act_sel, nxt_sel;
  logic             cur_hs, cur_vs, src_hs, src_vs;
  logic             frame_start;
  gate_t            gate;

  // Named views of the applied state for the bound checker.
  logic [1:0]       act_pwr;
  logic             act_hpos, act_vpos;

  assign wr_mode = '{pwr: pwr_e'(cfg_pwr), h_pos: cfg_hpos, v_pos: cfg_vpos};

  // Pipe currently applied: its vsync marks the frame start.
  aos_pipe_mux #(.NUM_PIPES(NUM_PIPES), .SEL_W(SEL_W)) u_cur_mux (
    .sel(act_sel), .hs_in(pipe_hsync), .vs_in(pipe_vsync),
    .hs_out(cur_hs), .vs_out(cur_vs)
  );

  aos_frame_edge u_edge (
    .clk(clk), .rst_n(rst_n), .vs(cur_vs), .frame_start(frame_start)
  );

  aos_cfg_regs #(.SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_mode(wr_mode), .wr_sel(cfg_pipe),
    .frame_start(frame_start), .act_mode(act_mode), .act_sel(act_sel),
    .nxt_mode(nxt_mode), .nxt_sel(nxt_sel)
  );

  // Pipe that drives the pins this edge (new setting if a frame starts now).
  aos_pipe_mux #(.NUM_PIPES(NUM_PIPES), .SEL_W(SEL_W)) u_src_mux (
    .sel(nxt_sel), .hs_in(pipe_hsync), .vs_in(pipe_vsync),
    .hs_out(src_hs), .vs_out(src_vs)
  );

  assign gate = decode_gate(nxt_mode.pwr);

  logic [LANES-1:0] lane_raw, lane_pos, lane_kill, lane_pin;
  assign lane_raw  = {src_vs, src_hs};
  assign lane_pos  = {nxt_mode.v_pos, nxt_mode.h_pos};
  assign lane_kill = {gate.v_kill, gate.h_kill};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    aos_sync_lane #(.RST_LEVEL(IDLE_RST)) u_lane (
      .clk(clk), .rst_n(rst_n), .raw(lane_raw[l]), .pos(lane_pos[l]),
      .kill(lane_kill[l]), .pin(lane_pin[l])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dac_en <= 1'b0;
    else        dac_en <= gate.dac_on;
  end

  assign hsync_out = lane_pin[0];
  assign vsync_out = lane_pin[1];
  assign act_pwr   = act_mode.pwr;
  assign act_hpos  = act_mode.h_pos;
  assign act_vpos  = act_mode.v_pos;

  logic unused_cur_hs;
  assign unused_cur_hs = cur_hs;
endmodule

// File: rtl/aos_checker.sv
module aos_checker #(
  parameter int SEL_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic [1:0]       act_pwr,
  input logic             act_hpos,
  input logic             act_vpos,
  input logic [SEL_W-1:0] act_sel,
  input logic             dac_en,
  input logic             hsync_out,
  input logic             vsync_out
);
  p_dac_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pwr != 2'd3) |-> dac_en);

  p_h_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pwr == 2'd1) |-> (hsync_out == !act_hpos));

  p_v_parked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pwr == 2'd2) |-> (vsync_out == !act_vpos));

  p_off_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pwr == 2'd3) |-> (!dac_en && hsync_out == !act_hpos && vsync_out == !act_vpos));

  p_frame_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_pwr) && $stable(act_hpos) && $stable(act_vpos) && $stable(act_sel)));
endmodule

bind analog_out_stage aos_checker #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .act_pwr(act_pwr),
  .act_hpos(act_hpos), .act_vpos(act_vpos), .act_sel(act_sel),
  .dac_en(dac_en), .hsync_out(hsync_out), .vsync_out(vsync_out)
);

// File: tb/analog_out_stage_tb.sv
module analog_out_stage_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_pwr = 2'd0;
  logic       cfg_hpos = 1'b0, cfg_vpos = 1'b0;
  logic [0:0] cfg_pipe = 1'b0;
  logic [1:0] pipe_hsync = 2'b00, pipe_vsync = 2'b00;
  logic       dac_en, hsync_out, vsync_out;

  int n_chk = 0, n_bad = 0;
  int ca = 0, cb = 0;

  // bench model state
  logic [1:0] m_pend_pwr = 2'd3, m_act_pwr = 2'd3;
  logic m_pend_h = 0, m_pend_v = 0, m_pend_s = 0;
  logic m_act_h = 0, m_act_v = 0, m_act_s = 0;
  logic m_vs_prev = 0;
  logic e_dac = 0, e_h = 1, e_v = 1;
  string e_tag = "R9";
  string extra = "";

  always #10 clk = ~clk;

  analog_out_stage u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pwr(cfg_pwr),
    .cfg_hpos(cfg_hpos), .cfg_vpos(cfg_vpos), .cfg_pipe(cfg_pipe),
    .pipe_hsync(pipe_hsync), .pipe_vsync(pipe_vsync),
    .dac_en(dac_en), .hsync_out(hsync_out), .vsync_out(vsync_out)
  );

  function automatic logic exp_pin(logic [1:0] pwr, logic pos, logic raw, bit is_h);
    logic parked;
    parked = is_h ? (pwr == 2'd1 || pwr == 2'd3) : (pwr == 2'd2 || pwr == 2'd3);
    return parked ? ~pos : (raw ~^ pos);
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // One cycle: compare, drive the next inputs, predict the next outputs.
  task automatic step(bit we, logic [1:0] p, logic h, logic v, logic s);
    logic vs_cur, fs, rh, rv;
    chk({e_tag, extra}, "dac_en", dac_en, e_dac);
    chk({e_tag, extra}, "hsync_out R5 R6", hsync_out, e_h);
    chk({e_tag, extra}, "vsync_out R5 R6", vsync_out, e_v);
    ca++; cb++;
    pipe_hsync = {((cb % 5) < 1), ((ca % 7) < 2)};
    pipe_vsync = {((cb % 47) < 3), ((ca % 63) < 4)};
    cfg_wr = we; cfg_pwr = p; cfg_hpos = h; cfg_vpos = v; cfg_pipe = s;
    vs_cur = m_act_s ? pipe_vsync[1] : pipe_vsync[0];
    fs = vs_cur && !m_vs_prev;
    m_vs_prev = vs_cur;
    if (fs) begin
      m_act_pwr = m_pend_pwr; m_act_h = m_pend_h; m_act_v = m_pend_v; m_act_s = m_pend_s;
    end
    if (we) begin
      m_pend_pwr = p; m_pend_h = h; m_pend_v = v; m_pend_s = s;
    end
    rh = m_act_s ? pipe_hsync[1] : pipe_hsync[0];
    rv = m_act_s ? pipe_vsync[1] : pipe_vsync[0];
    e_dac = (m_act_pwr != 2'd3);
    e_h = exp_pin(m_act_pwr, m_act_h, rh, 1'b1);
    e_v = exp_pin(m_act_pwr, m_act_v, rv, 1'b0);
    if ({m_pend_pwr, m_pend_h, m_pend_v, m_pend_s} != {m_act_pwr, m_act_h, m_act_v, m_act_s})
      e_tag = "R7";
    else case (m_act_pwr)
      2'd0: e_tag = "R1";
      2'd1: e_tag = "R2";
      2'd2: e_tag = "R3";
      default: e_tag = "R4";
    endcase
    @(negedge clk);
  endtask

  task automatic segment(logic [1:0] p, logic h, logic v, logic s);
    step(1'b1, p, h, v, s);
    for (int i = 0; i < 159; i++) step(1'b0, p, h, v, s);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R9", "dac_en in reset", dac_en, 1'b0);
    chk("R9", "hsync_out in reset", hsync_out, 1'b1);
    chk("R9", "vsync_out in reset", vsync_out, 1'b1);
    rst_n = 1'b1;
    segment(2'd0, 1'b1, 1'b1, 1'b0);   // R1 on, active high, pipe A
    segment(2'd1, 1'b1, 1'b1, 1'b0);   // R2 standby
    segment(2'd2, 1'b0, 1'b1, 1'b1);   // R3 suspend, pipe B
    segment(2'd3, 1'b1, 1'b0, 1'b1);   // R4 off
    segment(2'd0, 1'b0, 1'b0, 1'b1);   // R5 active low, R6 pipe B
    segment(2'd1, 1'b0, 1'b0, 1'b0);
    extra = " R8";
    segment(2'd2, 1'b0, 1'b0, 1'b0);   // R8 standby to suspend: hsync resumes
    segment(2'd0, 1'b1, 1'b0, 1'b0);   // R8 suspend to on: vsync resumes
    extra = "";
    for (int i = 0; i < 3000; i++) begin
      bit we;
      logic [3:0] r;
      we = ($urandom % 40) == 0;
      r = 4'($urandom);
      step(we, r[1:0], r[2], r[3], 1'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule